// File: doc/BRIEF.md
# Receive Power-Up Offset Calibration Sequencer

This block runs the power-up sequence of a two-channel receive path. The path is switched on when either an enable pin or an enable control bit goes high. The sequencer then steps through four timed phases before it raises a ready flag: a fixed settle phase, a programmable first wait, an optional offset calibration, and a programmable second wait. Every phase is measured in units of one output word period. By default that unit is 48 master clock cycles.

Each channel holds a 10-bit two's-complement offset value. The offset is weighted so that its LSB lands on bit 3 of the 15-bit filter sample. In automatic mode the offset is learned during the calibration phase. The block averages the first 16 filter results of that phase into the offset register. It can short the analog inputs during this phase (internal mode), or leave them connected so that system offsets are captured too (external mode). In user mode the host writes the offset directly. From the ready point onward, every filter sample leaves the block with its channel offset removed.

Top module: `rx_offset_cal_seq`

## Requirements
- R1: The receive path counts as enabled when `en_pin` OR `en_bit` is high. Either input alone starts the sequence.
- R2: The sequence is counted from the first clock edge that samples the enable high. `rx_ready` rises exactly (36 + D1 + 40·A + D2)·UNIT_CYC edges after that first edge, where A is `autocal_sel`. A zero D1 or D2 takes no time, and so does the calibration phase when A=0.
- R3: When the enable goes low in any phase, `rx_ready` is low after the next edge. A later enable restarts the whole timing from the settle phase.
- R4: `short_inputs` is high exactly during the calibration phase, and only when `extcal_sel`=0. With `extcal_sel`=1 it stays low throughout.
- R5: In calibration, each channel sums the first 16 valid samples of the phase and ignores later ones. The stored offset is floor(sum/128), saturated to [-512, 511].
- R6: Each corrected sample equals sample − offset·8, saturated to [-16384, 16383].
- R7: `out_vld` pulses one cycle after a valid input sample, and only while `rx_ready` is high. A sample taken outside ready produces no output.
- R8: A host offset write (`ofs_wr_en`, steered by `ofs_wr_ch`, where 0 selects channel 0) is accepted only while `autocal_sel`=0. In automatic mode the write is ignored.
- R9: Reset clears the offsets to zero. Otherwise an offset is kept across power-down and re-enable unless a calibration or an accepted write replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_pin | input | 1 | Receive enable from the pin |
| en_bit | input | 1 | Receive enable from the control register |
| autocal_sel | input | 1 | 1 = automatic offset calibration, 0 = user offsets |
| extcal_sel | input | 1 | 1 = keep inputs connected during calibration |
| dly1 | input | DLY_W | First programmable wait, in units |
| dly2 | input | DLY_W | Second programmable wait, in units |
| smp_vld | input | 1 | Filter output strobe |
| smp_data | input | NCH·SAMP_W | Filter samples; channel c occupies bits [c·SAMP_W +: SAMP_W] |
| ofs_wr_en | input | 1 | Host offset write strobe |
| ofs_wr_ch | input | max(1,clog2 NCH) | Channel index for the host write |
| ofs_wr_data | input | OFS_W | Offset value to write |
| short_inputs | output | 1 | Shorts the modulator inputs during internal calibration |
| out_vld | output | 1 | Corrected sample strobe |
| out_data | output | NCH·SAMP_W | Corrected samples, packed the same way as smp_data |
| rx_ready | output | 1 | Sequence complete; output words are valid |

## Verification
The bench builds the block with UNIT_CYC=4 and NCH=2, and leaves the sample and offset widths at their defaults. The short unit lets the bench run full 255-unit waits on both delays together with the 40-unit calibration in a few thousand cycles. It also makes every phase boundary land on a predictable edge count. Using two channels exercises the per-channel generate loop and the steering of host writes. The averaging and saturation checks drive opposite-signed values on the two channels.

// File: rtl/rxcal_pkg.sv
package rxcal_pkg;
   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_SETTLE = 3'd1,
      PH_WAITA  = 3'd2,
      PH_CAL    = 3'd3,
      PH_WAITB  = 3'd4,
      PH_READY  = 3'd5
   } rxcal_phase_e;
endpackage

// File: rtl/rxcal_unit_tick.sv
module rxcal_unit_tick #(
   parameter int UNIT_CYC = 48
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   localparam int PW = (UNIT_CYC > 1) ? $clog2(UNIT_CYC) : 1;

   if (UNIT_CYC < 2) begin : g_bad_unit
      $error("rxcal_unit_tick: UNIT_CYC must be at least 2");
   end

   logic [PW-1:0] pre_q;

   assign tick = (pre_q == PW'(UNIT_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pre_q <= '0;
      else if (restart || tick)  pre_q <= '0;
      else                       pre_q <= pre_q + 1'b1;
   end

   AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      pre_q <= PW'(UNIT_CYC - 1)); // R2
endmodule

// File: rtl/rxcal_seq_fsm.sv
module rxcal_seq_fsm
   import rxcal_pkg::*;
#(
   parameter int SETTLE_UNITS = 36,
   parameter int CAL_UNITS    = 40,
   parameter int DLY_W        = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             autocal,
   input  logic [DLY_W-1:0] dly1,
   input  logic [DLY_W-1:0] dly2,
   input  logic             tick,
   output rxcal_phase_e     phase,
   output logic             restart_tmr
);
   localparam int DLY_MAX = (1 << DLY_W) - 1;
   localparam int MAX_A   = (SETTLE_UNITS > CAL_UNITS) ? SETTLE_UNITS : CAL_UNITS;
   localparam int MAX_U   = (MAX_A > DLY_MAX) ? MAX_A : DLY_MAX;
   localparam int CNT_W   = $clog2(MAX_U + 1);

   if (SETTLE_UNITS < 1 || CAL_UNITS < 1) begin : g_bad_len
      $error("rxcal_seq_fsm: fixed phases need at least one unit");
   end

   rxcal_phase_e     phase_q, phase_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   function automatic logic [CNT_W-1:0] units_of(rxcal_phase_e p);
      case (p)
         PH_SETTLE: return CNT_W'(SETTLE_UNITS);
         PH_WAITA:  return CNT_W'(dly1);
         PH_CAL:    return CNT_W'(CAL_UNITS);
         PH_WAITB:  return CNT_W'(dly2);
         default:   return '0;
      endcase
   endfunction

   // next non-empty phase after p; empty phases are skipped
   function automatic rxcal_phase_e follow(rxcal_phase_e p);
      rxcal_phase_e r;
      r = PH_READY;
      if (p == PH_SETTLE && dly1 != '0)                               r = PH_WAITA;
      else if ((p == PH_SETTLE || p == PH_WAITA) && autocal)          r = PH_CAL;
      else if (p != PH_WAITB && p != PH_READY && dly2 != '0)          r = PH_WAITB;
      return r;
   endfunction

   always_comb begin
      phase_d = phase_q;
      cnt_d   = cnt_q;
      if (!en) begin
         phase_d = PH_IDLE;
         cnt_d   = '0;
      end else begin
         case (phase_q)
            PH_IDLE: begin
               phase_d = PH_SETTLE;
               cnt_d   = units_of(PH_SETTLE);
            end
            PH_READY: ;
            default: begin
               if (tick) begin
                  if (cnt_q <= CNT_W'(1)) begin
                     phase_d = follow(phase_q);
                     cnt_d   = units_of(phase_d);
                  end else begin
                     cnt_d = cnt_q - 1'b1;
                  end
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
      end
   end

   assign phase       = phase_q;
   assign restart_tmr = (phase_d != phase_q) || (phase_q == PH_IDLE);

   AST_IDLE_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (phase_q == PH_IDLE)); // R3
   AST_START_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_IDLE && en) |=> (phase_q == PH_SETTLE)); // R2
endmodule

// File: rtl/rxcal_chan.sv
module rxcal_chan #(
   parameter int SAMP_W  = 15,
   parameter int OFS_W   = 10,
   parameter int OFS_LSB = 3,
   parameter int AVG_N   = 16,
   parameter bit SAT_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cal_active,
   input  logic              autocal,
   input  logic              wr_hit,
   input  logic [OFS_W-1:0]  wr_data,
   input  logic              smp_vld,
   input  logic [SAMP_W-1:0] smp,
   input  logic              emit,
   output logic [SAMP_W-1:0] out_q
);
   localparam int AVG_SH = $clog2(AVG_N);
   localparam int ACC_W  = SAMP_W + AVG_SH;
   localparam int NW     = $clog2(AVG_N + 1);
   localparam int DW     = SAMP_W + 1;
   localparam int SH     = AVG_SH + OFS_LSB;
   localparam logic signed [ACC_W-1:0] OFS_HI = ACC_W'((2 ** (OFS_W - 1)) - 1);
   localparam logic signed [ACC_W-1:0] OFS_LO = -OFS_HI - 1;
   localparam logic signed [DW-1:0]    OUT_HI = DW'((2 ** (SAMP_W - 1)) - 1);
   localparam logic signed [DW-1:0]    OUT_LO = -OUT_HI - 1;

   if ((1 << AVG_SH) != AVG_N || AVG_N < 2) begin : g_bad_avg
      $error("rxcal_chan: AVG_N must be a power of two >= 2");
   end
   if (OFS_W + OFS_LSB > SAMP_W) begin : g_bad_ofs
      $error("rxcal_chan: offset field exceeds sample width");
   end

   logic signed [ACC_W-1:0] acc_q, acc_nxt, avg_sh;
   logic [NW-1:0]           n_q;
   logic signed [OFS_W-1:0] ofs_q, ofs_cal;
   logic                    take, cal_done;
   logic signed [DW-1:0]    diff;
   logic [SAMP_W-1:0]       corr;

   assign take     = cal_active && smp_vld && (n_q < NW'(AVG_N));
   assign cal_done = take && (n_q == NW'(AVG_N - 1));
   assign acc_nxt  = acc_q + ACC_W'($signed(smp));
   assign avg_sh   = acc_nxt >>> SH;

   always_comb begin
      if (avg_sh > OFS_HI)      ofs_cal = OFS_HI[OFS_W-1:0];
      else if (avg_sh < OFS_LO) ofs_cal = OFS_LO[OFS_W-1:0];
      else                      ofs_cal = avg_sh[OFS_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         n_q   <= '0;
         ofs_q <= '0;
      end else begin
         if (!cal_active) begin
            acc_q <= '0;
            n_q   <= '0;
         end else if (take) begin
            acc_q <= acc_nxt;
            n_q   <= n_q + 1'b1;
         end
         if (cal_done)                ofs_q <= ofs_cal;
         else if (wr_hit && !autocal) ofs_q <= wr_data;
      end
   end

   assign diff = DW'($signed(smp)) - (DW'(ofs_q) <<< OFS_LSB);

   if (SAT_OUT) begin : g_sat
      always_comb begin
         if (diff > OUT_HI)      corr = OUT_HI[SAMP_W-1:0];
         else if (diff < OUT_LO) corr = OUT_LO[SAMP_W-1:0];
         else                    corr = diff[SAMP_W-1:0];
      end
   end else begin : g_wrap
      assign corr = diff[SAMP_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    out_q <= '0;
      else if (emit) out_q <= corr;
   end

   AST_OFS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cal_active && !(wr_hit && !autocal)) |=> $stable(ofs_q)); // R9
   AST_AVG_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      n_q <= NW'(AVG_N)); // R5
endmodule

// File: rtl/rx_offset_cal_seq.sv
module rx_offset_cal_seq
   import rxcal_pkg::*;
#(
   parameter int UNIT_CYC     = 48,
   parameter int SETTLE_UNITS = 36,
   parameter int CAL_UNITS    = 40,
   parameter int DLY_W        = 8,
   parameter int NCH          = 2,
   parameter int SAMP_W       = 15,
   parameter int OFS_W        = 10,
   parameter int OFS_LSB      = 3,
   parameter int AVG_N        = 16,
   parameter bit SAT_OUT      = 1'b1
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  en_pin,
   input  logic                                  en_bit,
   input  logic                                  autocal_sel,
   input  logic                                  extcal_sel,
   input  logic [DLY_W-1:0]                      dly1,
   input  logic [DLY_W-1:0]                      dly2,
   input  logic                                  smp_vld,
   input  logic [NCH*SAMP_W-1:0]                 smp_data,
   input  logic                                  ofs_wr_en,
   input  logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] ofs_wr_ch,
   input  logic [OFS_W-1:0]                      ofs_wr_data,
   output logic                                  short_inputs,
   output logic                                  out_vld,
   output logic [NCH*SAMP_W-1:0]                 out_data,
   output logic                                  rx_ready
);
   localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

   if (NCH < 1) begin : g_bad_nch
      $error("rx_offset_cal_seq: NCH must be at least 1");
   end

   logic         en_any, tick, restart_tmr, cal_active, emit;
   rxcal_phase_e phase;

   assign en_any = en_pin | en_bit;

   rxcal_unit_tick #(.UNIT_CYC(UNIT_CYC)) u_tick (
      .clk(clk), .rst_n(rst_n), .restart(restart_tmr), .tick(tick)
   );

   rxcal_seq_fsm #(
      .SETTLE_UNITS(SETTLE_UNITS), .CAL_UNITS(CAL_UNITS), .DLY_W(DLY_W)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .en(en_any), .autocal(autocal_sel),
      .dly1(dly1), .dly2(dly2), .tick(tick),
      .phase(phase), .restart_tmr(restart_tmr)
   );

   assign cal_active   = (phase == PH_CAL);
   assign short_inputs = cal_active && !extcal_sel;
   assign rx_ready     = (phase == PH_READY);
   assign emit         = smp_vld && rx_ready;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      rxcal_chan #(
         .SAMP_W(SAMP_W), .OFS_W(OFS_W), .OFS_LSB(OFS_LSB),
         .AVG_N(AVG_N), .SAT_OUT(SAT_OUT)
      ) u_ch (
         .clk(clk), .rst_n(rst_n), .cal_active(cal_active),
         .autocal(autocal_sel),
         .wr_hit(ofs_wr_en && (ofs_wr_ch == CH_W'(c))),
         .wr_data(ofs_wr_data), .smp_vld(smp_vld),
         .smp(smp_data[c*SAMP_W +: SAMP_W]), .emit(emit),
         .out_q(out_data[c*SAMP_W +: SAMP_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_vld <= 1'b0;
      else        out_vld <= emit;
   end

   AST_READY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      !en_any |=> !rx_ready); // R3
   AST_SHORT_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      short_inputs |-> !rx_ready); // R4
   AST_VLD_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> $past(rx_ready)); // R7
endmodule

// File: tb/tb_rx_offset_cal_seq.sv
module tb_rx_offset_cal_seq;
   localparam int U  = 4;
   localparam int NC = 2;
   localparam int SW = 15;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en_pin = 0, en_bit = 0, autocal_sel = 0, extcal_sel = 0;
   logic [7:0] dly1 = 0, dly2 = 0;
   logic smp_vld = 0;
   logic [NC*SW-1:0] smp_data = '0;
   logic ofs_wr_en = 0;
   logic [0:0] ofs_wr_ch = 0;
   logic [9:0] ofs_wr_data = 0;
   logic short_inputs, out_vld, rx_ready;
   logic [NC*SW-1:0] out_data;

   int checks = 0, errors = 0, edges = 0, cyc = 0;

   rx_offset_cal_seq #(.UNIT_CYC(U), .NCH(NC)) dut (
      .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .en_bit(en_bit),
      .autocal_sel(autocal_sel), .extcal_sel(extcal_sel),
      .dly1(dly1), .dly2(dly2), .smp_vld(smp_vld), .smp_data(smp_data),
      .ofs_wr_en(ofs_wr_en), .ofs_wr_ch(ofs_wr_ch), .ofs_wr_data(ofs_wr_data),
      .short_inputs(short_inputs), .out_vld(out_vld), .out_data(out_data),
      .rx_ready(rx_ready)
   );

   always #5 clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      edges++;
      @(negedge clk);
   endtask

   function automatic int ch_out(int c);
      return int'($signed(out_data[c*SW +: SW]));
   endfunction

   task automatic set_smp(int s0, int s1);
      smp_data[0 +: SW]  = SW'(s0);
      smp_data[SW +: SW] = SW'(s1);
   endtask

   // apply one sample pair and check the corrected pair (R6, R7)
   task automatic apply(string req, int s0, int s1, int e0, int e1);
      set_smp(s0, s1);
      smp_vld = 1;
      step();
      smp_vld = 0;
      chk({req, " out_vld"}, int'(out_vld), 1);
      chk({req, " ch0"}, ch_out(0), e0);
      chk({req, " ch1"}, ch_out(1), e1);
   endtask

   task automatic write_ofs(int ch, int val);
      ofs_wr_ch = 1'(ch);
      ofs_wr_data = 10'(val);
      ofs_wr_en = 1;
      step();
      ofs_wr_en = 0;
   endtask

   task automatic wait_ready(string req, int exp, output bit sh_seen);
      sh_seen = 0;
      while (!rx_ready && edges < 5000) begin
         step();
         if (short_inputs) sh_seen = 1;
      end
      chk(req, edges, exp);
   endtask

   task automatic power_off();
      en_pin = 0;
      en_bit = 0;
      step();
   endtask

   task automatic t_reset();
      chk("R7 reset out_vld", int'(out_vld), 0);
      chk("R3 reset rx_ready", int'(rx_ready), 0);
      chk("R4 reset short", int'(short_inputs), 0);
   endtask

   task automatic t_user();
      bit sh;
      autocal_sel = 0; dly1 = 3; dly2 = 2;
      write_ofs(0, 5);
      write_ofs(1, -512);
      en_pin = 1; edges = 0;
      wait_ready("R2 R1 pin start d1=3 d2=2", 1 + 41*U, sh);
      chk("R4 no short in user mode", int'(sh), 0);
      apply("R6 basic", 100, -50, 60, 4046);
      apply("R6 positive saturation", 0, 16383, -40, 16383);
   endtask

   task automatic t_disable();
      power_off();
      chk("R3 ready drops", int'(rx_ready), 0);
      set_smp(7, 7);
      smp_vld = 1;
      step();
      smp_vld = 0;
      chk("R7 no output when not ready", int'(out_vld), 0);
   endtask

   task automatic t_enbit();
      bit sh;
      dly1 = 0; dly2 = 0;
      en_bit = 1; edges = 0;
      wait_ready("R1 R2 bit start zero delays", 1 + 36*U, sh);
      power_off();
   endtask

   task automatic t_autocal_int();
      bit sh;
      autocal_sel = 1; extcal_sel = 0; dly1 = 0; dly2 = 1;
      en_pin = 1; edges = 0;
      while (!short_inputs && edges < 5000) step();
      chk("R4 short rises at calibration", edges, 1 + 36*U);
      for (int i = 0; i < 16; i++) begin
         set_smp(1000, -300);
         smp_vld = 1;
         step();
      end
      for (int i = 0; i < 4; i++) begin
         set_smp(8000, 8000);
         step();
      end
      smp_vld = 0;
      wait_ready("R2 autocal total", 1 + 77*U, sh);
      chk("R4 short low at ready", int'(short_inputs), 0);
      apply("R5 averaged offsets", 1000, -300, 0, 4);
   endtask

   task automatic t_ignore_wr();
      write_ofs(0, 0);
      apply("R8 write ignored in autocal", 1000, 0, 0, 304);
   endtask

   task automatic t_retain();
      bit sh;
      power_off();
      autocal_sel = 0; dly1 = 0; dly2 = 0;
      en_pin = 1; edges = 0;
      wait_ready("R2 user restart", 1 + 36*U, sh);
      apply("R9 offsets retained", 0, 0, -1000, 304);
   endtask

   task automatic t_restart();
      bit sh;
      power_off();
      dly1 = 10; dly2 = 0;
      en_pin = 1; edges = 0;
      for (int i = 0; i < 150; i++) step();
      en_pin = 0;
      step();
      chk("R3 idle mid-sequence no ready", int'(rx_ready), 0);
      en_pin = 1; edges = 0;
      wait_ready("R3 restart full timing", 1 + 46*U, sh);
   endtask

   task automatic t_autocal_ext();
      bit sh;
      power_off();
      autocal_sel = 1; extcal_sel = 1; dly1 = 255; dly2 = 255;
      en_pin = 1; edges = 0;
      sh = 0;
      while (edges < 1 + 291*U) begin
         step();
         if (short_inputs) sh = 1;
      end
      for (int i = 0; i < 16; i++) begin
         set_smp(16000, -16384);
         smp_vld = 1;
         step();
         if (short_inputs) sh = 1;
      end
      smp_vld = 0;
      chk("R4 external mode keeps inputs", int'(sh), 0);
      wait_ready("R2 max delays with cal", 1 + 586*U, sh);
      chk("R4 external no short", int'(sh), 0);
      apply("R5 offset saturation", 0, 0, -4088, 4096);
      apply("R6 saturation both signs", -16000, 16000, -16384, 16383);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_user();
      t_disable();
      t_enbit();
      t_autocal_int();
      t_ignore_wr();
      t_retain();
      t_restart();
      t_autocal_ext();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule